// File: doc/BRIEF.md
# Dual-Issue Warp Scheduler with Latency Scoreboard

This block decides, every clock cycle, which resident warps send their next instruction to a fixed-latency arithmetic pipeline. Each warp slot shows a descriptor for its next instruction: a pending flag, a destination register and two source registers. A warp slot also has a residency bit. Per warp and per register, a countdown records a result that is still travelling through the pipeline. An instruction may go only when no register it names is still counting down.

Up to two instructions issue per cycle, and they come from two different warps. The choice is round-robin across all resident warps and starts after the warp granted most recently. A warp that issued in the previous cycle stands aside while any other warp is eligible. Consecutive issue slots therefore interleave across warps, even when one warp holds independent work. All warp state stays resident, so moving from one warp to another costs no cycle.

A small controller has two states. In `SCH_IDLE` the previous cycle issued nothing and every eligible warp competes. In `SCH_ISSUED` at least one warp issued in the previous cycle, and those warps lose to any other eligible warp. The controller moves from `SCH_IDLE` to `SCH_ISSUED` (transition *grant*) when slot 0 issues. It stays in `SCH_ISSUED` (transition *keep*) while issuing continues. It returns to `SCH_IDLE` (transition *drain*) in any cycle with no issue.

Top module: `warp_issue_sched`

## Requirements
- R1: On reset every countdown is zero, the controller is in `SCH_IDLE`, no warp counts as previously issued, and the round-robin pointer sits at the highest warp, so the first search begins at warp 0.
- R2: A warp is a candidate only when both its `warp_valid` bit and its `instr_valid` bit are 1. Warp w's descriptor fields occupy bits `[w*RW +: RW]` of `instr_dst`, `instr_src_a` and `instr_src_b`.
- R3: An issued instruction marks its destination register busy in its own warp for LAT cycles (LAT defaults to 12). An instruction whose destination or either source is busy is held. A producer issued in cycle t lets such a dependent issue in cycle t+LAT at the earliest.
- R4: Countdowns are private to each warp. A busy register in one warp never holds an instruction of another warp that names the same register number.
- R5: Slot 0 grants the first eligible warp in ascending, wrapping order after the pointer. The pointer then becomes the slot-1 warp when two issue, and the slot-0 warp when one issues.
- R6: Slot 1 grants the next warp of the same candidate pool after the slot-0 warp. It is never the slot-0 warp.
- R7: Warps that issued in the previous cycle are removed from the pool whenever another eligible warp exists. If no other warp is eligible, they may issue again.
- R8: A cycle with no eligible warp issues nothing. A cycle with at least one eligible warp issues on slot 0 in that same cycle.
- R9: `issue1_valid` is high only together with `issue0_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_valid | input | NW | Residency bit per warp slot |
| instr_valid | input | NW | Next instruction present, per warp |
| instr_dst | input | NW*RW | Destination register per warp |
| instr_src_a | input | NW*RW | First source register per warp |
| instr_src_b | input | NW*RW | Second source register per warp |
| issue0_valid | output | 1 | Slot 0 issues this cycle |
| issue0_warp | output | WW | Warp granted on slot 0 |
| issue1_valid | output | 1 | Slot 1 issues this cycle |
| issue1_warp | output | WW | Warp granted on slot 1 |

## Verification
A countdown stuck above zero shows as a warp that stays silent past its LAT-cycle window. A countdown cleared early lets a dependent issue sooner than LAT cycles after its producer. Either fault is visible at the issue ports within LAT+1 cycles. A pointer or previous-issue mask holding a wrong value changes the granted warp IDs on the very next cycle with two or more eligible warps. The bench therefore pins exact warp IDs on consecutive cycles and checks the exact cycle in which a held instruction is released.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

    // Controller state: whether the previous cycle granted any warp
    typedef enum logic {
        SCH_IDLE   = 1'b0,
        SCH_ISSUED = 1'b1
    } sched_state_e;

endpackage

// File: rtl/warp_sb.sv
// Per-warp register countdowns. Reports which warps have a hazard-free
// next instruction.
module warp_sb #(
    parameter int NW  = 4,
    parameter int NR  = 8,
    parameter int LAT = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NW*$clog2(NR)-1:0]      dst_flat,
    input  logic [NW*$clog2(NR)-1:0]      sa_flat,
    input  logic [NW*$clog2(NR)-1:0]      sb_flat,
    input  logic [NW-1:0]                 grant_mask,
    output logic [NW-1:0]                 hazard_free
);
    localparam int RW = $clog2(NR);
    localparam int CW = $clog2(LAT + 1);
    localparam logic [CW-1:0] RELOAD = CW'(LAT - 1);

    for (genvar w = 0; w < NW; w++) begin : g_warp
        logic [CW-1:0] cnt_q [NR];
        logic [RW-1:0] d_reg, a_reg, b_reg;

        assign d_reg = dst_flat[w*RW +: RW];
        assign a_reg = sa_flat[w*RW +: RW];
        assign b_reg = sb_flat[w*RW +: RW];

        for (genvar r = 0; r < NR; r++) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q[r] <= '0;
                end else if (grant_mask[w] && (d_reg == RW'(r))) begin
                    cnt_q[r] <= RELOAD;
                end else if (cnt_q[r] != '0) begin
                    cnt_q[r] <= cnt_q[r] - 1'b1;
                end
            end
        end

        assign hazard_free[w] = (cnt_q[d_reg] == '0) &&
                                (cnt_q[a_reg] == '0) &&
                                (cnt_q[b_reg] == '0);
    end

endmodule

// File: rtl/warp_rr_pick.sv
// First set bit of a mask, searching upward and wrapping, starting
// just after a given index.
module warp_rr_pick #(
    parameter int NW = 4
) (
    input  logic [NW-1:0]          mask,
    input  logic [$clog2(NW)-1:0]  after,
    output logic                   found,
    output logic [$clog2(NW)-1:0]  idx
);
    localparam int WW = $clog2(NW);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        // Descending offsets so that the nearest hit is written last
        for (int k = NW; k >= 1; k--) begin
            if (mask[(int'(after) + k) % NW]) begin
                found = 1'b1;
                idx   = WW'((int'(after) + k) % NW);
            end
        end
    end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
    import warp_sched_pkg::*;
#(
    parameter int NW  = 4,
    parameter int NR  = 8,
    parameter int LAT = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NW-1:0]             warp_valid,
    input  logic [NW-1:0]             instr_valid,
    input  logic [NW*$clog2(NR)-1:0]  instr_dst,
    input  logic [NW*$clog2(NR)-1:0]  instr_src_a,
    input  logic [NW*$clog2(NR)-1:0]  instr_src_b,
    output logic                      issue0_valid,
    output logic [$clog2(NW)-1:0]     issue0_warp,
    output logic                      issue1_valid,
    output logic [$clog2(NW)-1:0]     issue1_warp
);
    localparam int WW = $clog2(NW);
    localparam logic [WW-1:0] PTR_INIT = WW'(NW - 1);

    sched_state_e  state_q, state_d;
    logic [NW-1:0] prev_q;
    logic [WW-1:0] ptr_q;

    logic [NW-1:0] hazard_free, eligible, others, pool, pool1, grant_mask;
    logic          f0, f1;
    logic [WW-1:0] w0, w1;

    warp_sb #(.NW(NW), .NR(NR), .LAT(LAT)) u_sb (
        .clk         (clk),
        .rst_n       (rst_n),
        .dst_flat    (instr_dst),
        .sa_flat     (instr_src_a),
        .sb_flat     (instr_src_b),
        .grant_mask  (grant_mask),
        .hazard_free (hazard_free)
    );

    assign eligible = warp_valid & instr_valid & hazard_free;
    assign others   = eligible & ~prev_q;

    warp_rr_pick #(.NW(NW)) u_pick0 (
        .mask  (pool),
        .after (ptr_q),
        .found (f0),
        .idx   (w0)
    );

    assign pool1 = f0 ? (pool & ~(NW'(1) << w0)) : '0;

    warp_rr_pick #(.NW(NW)) u_pick1 (
        .mask  (pool1),
        .after (w0),
        .found (f1),
        .idx   (w1)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SCH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Pool selection, outputs and next state
    always_comb begin
        pool    = eligible;
        state_d = state_q;
        unique case (state_q)
            SCH_IDLE: begin
                pool = eligible;
                if (f0) state_d = SCH_ISSUED;          // grant
            end
            SCH_ISSUED: begin
                pool = (others != '0) ? others : eligible;
                if (!f0) state_d = SCH_IDLE;           // drain; else keep
            end
        endcase
        issue0_valid = f0;
        issue0_warp  = w0;
        issue1_valid = f1;
        issue1_warp  = w1;
        grant_mask   = ({NW{f0}} & (NW'(1) << w0)) |
                       ({NW{f1}} & (NW'(1) << w1));
    end

    // Round-robin pointer and previous-grant record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= PTR_INIT;
            prev_q <= '0;
        end else begin
            prev_q <= grant_mask;
            if (f1) begin
                ptr_q <= w1;
            end else if (f0) begin
                ptr_q <= w0;
            end
        end
    end

endmodule

// File: rtl/warp_sched_checker.sv
module warp_sched_checker #(
    parameter int NW = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NW-1:0]          warp_valid,
    input logic [NW-1:0]          instr_valid,
    input logic                   issue0_valid,
    input logic [$clog2(NW)-1:0]  issue0_warp,
    input logic                   issue1_valid,
    input logic [$clog2(NW)-1:0]  issue1_warp
);
    a_r9_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
        issue1_valid |-> issue0_valid);

    a_r6_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        issue1_valid |-> (issue1_warp != issue0_warp));

    a_r2_gate_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        issue0_valid |-> (warp_valid[issue0_warp] && instr_valid[issue0_warp]));

    a_r2_gate_slot1: assert property (@(posedge clk) disable iff (!rst_n)
        issue1_valid |-> (warp_valid[issue1_warp] && instr_valid[issue1_warp]));

    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((warp_valid & instr_valid) == '0) |-> !issue0_valid);

    // A lone warp repeating on slot 0 means no other warp was eligible
    a_r7_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(issue0_valid) && !$past(issue1_valid) &&
         issue0_valid && (issue0_warp == $past(issue0_warp))) |-> !issue1_valid);

endmodule

bind warp_issue_sched warp_sched_checker #(.NW(NW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .warp_valid   (warp_valid),
    .instr_valid  (instr_valid),
    .issue0_valid (issue0_valid),
    .issue0_warp  (issue0_warp),
    .issue1_valid (issue1_valid),
    .issue1_warp  (issue1_warp)
);

// File: tb/warp_issue_sched_test.sv
module warp_issue_sched_test;
    localparam int NW = 4;
    localparam int NR = 8;
    localparam int LAT = 12;
    localparam int RW = 3;
    localparam int WW = 2;
    localparam int NV = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NW-1:0] warp_valid = '0;
    logic [NW-1:0] instr_valid = '0;
    logic [RW-1:0] dst = '0, sa = '0, sb = '0;
    logic issue0_valid, issue1_valid;
    logic [WW-1:0] issue0_warp, issue1_warp;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    warp_issue_sched #(.NW(NW), .NR(NR), .LAT(LAT)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .warp_valid   (warp_valid),
        .instr_valid  (instr_valid),
        .instr_dst    ({NW{dst}}),
        .instr_src_a  ({NW{sa}}),
        .instr_src_b  ({NW{sb}}),
        .issue0_valid (issue0_valid),
        .issue0_warp  (issue0_warp),
        .issue1_valid (issue1_valid),
        .issue1_warp  (issue1_warp)
    );

    // {warp_valid, instr_valid, dst, exp i0v, i0w, i1v, i1w}; sources = 7
    localparam logic [16:0] VEC [NV] = '{
        {4'b1111, 4'b1111, 3'd0, 1'b1, 2'd0, 1'b1, 2'd1}, // R1 R5 R6
        {4'b1111, 4'b1111, 3'd1, 1'b1, 2'd2, 1'b1, 2'd3}, // R7 R5
        {4'b1111, 4'b0001, 3'd2, 1'b1, 2'd0, 1'b0, 2'd0}, // R2
        {4'b1111, 4'b0001, 3'd3, 1'b1, 2'd0, 1'b0, 2'd0}, // R7 lone repeat
        {4'b0101, 4'b1111, 3'd4, 1'b1, 2'd2, 1'b0, 2'd0}, // R7 R2
        {4'b0000, 4'b1111, 3'd5, 1'b0, 2'd0, 1'b0, 2'd0}, // R8
        {4'b1011, 4'b1011, 3'd6, 1'b1, 2'd3, 1'b1, 2'd0}, // R5 wrap, R9
        {4'b1111, 4'b1111, 3'd7, 1'b1, 2'd1, 1'b1, 2'd2}  // R7 R6
    };

    task automatic check(input string tag, input logic e0v, input logic [WW-1:0] e0w,
                         input logic e1v, input logic [WW-1:0] e1w);
        logic [5:0] act, exp;
        act = {issue0_valid, issue0_valid ? issue0_warp : 2'd0,
               issue1_valid, issue1_valid ? issue1_warp : 2'd0};
        exp = {e0v, e0v ? e0w : 2'd0, e1v, e1v ? e1w : 2'd0};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual v0=%b w0=%0d v1=%b w1=%0d expected v0=%b w0=%0d v1=%b w1=%0d",
                     tag, act[5], act[4:3], act[2], act[1:0],
                     exp[5], exp[4:3], exp[2], exp[1:0]);
        end
    endtask

    task automatic drive(input logic [NW-1:0] wv, input logic [NW-1:0] iv,
                         input logic [RW-1:0] d, input logic [RW-1:0] a,
                         input logic [RW-1:0] b);
        @(negedge clk);
        warp_valid = wv; instr_valid = iv; dst = d; sa = a; sb = b;
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; warp_valid = '0; instr_valid = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R1 R8: nothing pending after reset, nothing issues
        drive(4'b1111, 4'b0000, 3'd0, 3'd7, 3'd7);
        check("R1", 1'b0, 2'd0, 1'b0, 2'd0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][16:13], VEC[i][12:9], VEC[i][8:6], 3'd7, 3'd7);
            check($sformatf("R5 vector %0d", i), VEC[i][5], VEC[i][4:3],
                  VEC[i][2], VEC[i][1:0]);
        end

        // R3: dependent waits exactly LAT cycles
        do_reset();
        drive(4'b1111, 4'b0010, 3'd2, 3'd5, 3'd5);
        check("R3 producer", 1'b1, 2'd1, 1'b0, 2'd0);
        for (int k = 1; k < LAT; k++) begin
            drive(4'b1111, 4'b0010, 3'd3, 3'd2, 3'd5);
            check($sformatf("R3 held cycle %0d", k), 1'b0, 2'd0, 1'b0, 2'd0);
        end
        drive(4'b1111, 4'b0010, 3'd3, 3'd2, 3'd5);
        check("R3 release", 1'b1, 2'd1, 1'b0, 2'd0);

        // R4: another warp is not held by warp 1's busy register
        do_reset();
        drive(4'b1111, 4'b0010, 3'd2, 3'd5, 3'd5);
        check("R4 producer", 1'b1, 2'd1, 1'b0, 2'd0);
        drive(4'b1111, 4'b0011, 3'd3, 3'd2, 3'd5);
        check("R4", 1'b1, 2'd0, 1'b0, 2'd0);
        // R3 write-after-write: warp 0's destination now busy
        drive(4'b1111, 4'b0011, 3'd3, 3'd2, 3'd5);
        check("R3 waw", 1'b0, 2'd0, 1'b0, 2'd0);
        // R8: resident warps with nothing pending
        drive(4'b1111, 4'b0000, 3'd0, 3'd7, 3'd7);
        check("R8", 1'b0, 2'd0, 1'b0, 2'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule